// File: doc/BRIEF.md
# Fixed-Weight Subset Sequencer

The sequencer walks through every pattern of `n` bits that holds exactly `k` ones, producing one new pattern per accepted step. A load command captures the weight and the active width and presents the first pattern of that weight in the next cycle. Each following step replaces the current pattern with its successor in a fixed order. The `last` flag marks the final pattern of the weight. An outer controller that wants every pattern in order of rising weight loads `k = 1`, steps until `last`, and then loads `k + 1`.

Bit `i` of `pattern` is position `i`. In a written pattern such as `100`, the leftmost character is position 0. Seen as an unsigned number in which position `i` carries weight 2^i, the order is ascending numeric order among the values with `k` ones below 2^n.

Top module: `fwseq_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `valid` and `last` are 0 and `pattern` is all zeros.
- R2: A load with 1 <= `k_in` <= `n_in` <= MAX_W (default 16) makes `valid` 1 in the next cycle. `pattern` then has positions 0 to `k_in`-1 set and every other position clear.
- R3: A step while `valid` is 1 and `last` is 0 takes effect in the next cycle, which shows the successor. The successor is found by scanning upward from position 0 for the first set bit whose next-higher position is clear and lies below `n`, counting the set bits up to and including that bit. That bit moves up by one position, every position below it is cleared, and the lowest (count-1) positions are set.
- R4: `last` is 1 exactly when `valid` is 1 and no successor exists, that is, when the ones fill positions `n`-`k` to `n`-1. A step on that pattern makes `valid` 0 and `pattern` zero in the next cycle.
- R5: A load with `k_in` = 0, `k_in` > `n_in`, `n_in` = 0 or `n_in` > MAX_W is rejected: in the next cycle `valid` and `last` are 0 and `pattern` is zero.
- R6: Positions at or above the captured width `n` are always 0, and every accepted step keeps the number of ones unchanged.
- R7: With neither load nor step, outputs hold. A step while `valid` is 0 is ignored. Load takes priority over a step in the same cycle. `k_in` and `n_in` are sampled only on load.
- R8: Starting from the load, the walk for weight `k` and width `n` visits each of the C(n,k) patterns exactly once. For `n` = 3 the order is 100, 010, 001 at `k` = 1; 110, 101, 011 at `k` = 2; and 111 at `k` = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Capture `k_in` and `n_in` and start a new walk |
| step | input | 1 | Advance to the successor pattern |
| k_in | input | CW (5) | Number of ones per pattern |
| n_in | input | CW (5) | Active width in bits |
| pattern | output | MAX_W (16) | Current pattern; bit i is position i |
| valid | output | 1 | A pattern of the loaded weight is present |
| last | output | 1 | Current pattern is the final one of its weight |

## Verification
The hardest situation to reach from the ports is the final pattern of a wide, mid-weight walk, such as `n` = 16 with `k` near 8. Thousands of steps lie between the load and that pattern. The stimulus reaches the `last` boundary and the drop of `valid` in two ways: it walks small widths to exhaustion, and it loads the few weights whose walks are short at the widest setting (`k` = 1, `k` = 15, `k` = 16). Random trials with irregular step gaps, and with `k_in` and `n_in` changed between loads, then cover the middle of the successor rule. A reference model built on integer arithmetic predicts every cycle.

// File: rtl/fwseq_pkg.sv
package fwseq_pkg;
  // Action selected by the next-state logic in one cycle.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_ADV  = 2'd2,
    ACT_DONE = 2'd3
  } fwseq_act_e;
endpackage

// File: rtl/fwseq_rst_sync.sv
module fwseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/fwseq_admit.sv
// Checks a load request and builds the first pattern of the weight.
module fwseq_admit #(
  parameter int MAX_W = 16,
  parameter int CW    = $clog2(MAX_W + 1)
) (
  input  logic [CW-1:0]    k_in,
  input  logic [CW-1:0]    n_in,
  output logic             ok,
  output logic [MAX_W-1:0] first
);
  assign ok = (k_in != '0) && (n_in != '0) && (k_in <= n_in) &&
              (n_in <= CW'(MAX_W));

  for (genvar j = 0; j < MAX_W; j++) begin : g_first
    assign first[j] = (CW'(j) < k_in);
  end
endmodule

// File: rtl/fwseq_next.sv
// Combinational successor: move the lowest movable one up, repack below.
module fwseq_next #(
  parameter int MAX_W = 16,
  parameter int CW    = $clog2(MAX_W + 1)
) (
  input  logic [MAX_W-1:0] cur,
  input  logic [CW-1:0]    n_q,
  output logic [MAX_W-1:0] nxt,
  output logic             has_next
);
  logic          found;
  logic [CW-1:0] pivot;
  logic [CW-1:0] ones;

  always_comb begin
    found = 1'b0;
    pivot = '0;
    ones  = '0;
    for (int i = 0; i < MAX_W - 1; i++) begin
      if (!found) begin
        if (cur[i]) ones = ones + CW'(1);
        if (cur[i] && !cur[i+1] && (CW'(i + 1) < n_q)) begin
          found = 1'b1;
          pivot = CW'(i);
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < MAX_W; j++) begin
      if (CW'(j) == pivot + CW'(1))
        nxt[j] = 1'b1;
      else if (CW'(j) <= pivot)
        nxt[j] = (CW'(j) + CW'(1) < ones);
      else
        nxt[j] = cur[j];
    end
  end

  assign has_next = found;
endmodule

// File: rtl/fwseq_top.sv
module fwseq_top #(
  parameter int MAX_W = 16,
  parameter int CW    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CW-1:0]    k_in,
  input  logic [CW-1:0]    n_in,
  output logic [MAX_W-1:0] pattern,
  output logic             valid,
  output logic             last
);
  import fwseq_pkg::*;

  logic             rst_n_s;
  logic [MAX_W-1:0] pat_q, pat_d;
  logic             vld_q, vld_d;
  logic [CW-1:0]    n_q, n_d;
  logic             upd_en;
  logic             cfg_ok;
  logic [MAX_W-1:0] first_pat;
  logic [MAX_W-1:0] succ_pat;
  logic             succ_ok;
  fwseq_act_e       act;

  fwseq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  fwseq_admit #(.MAX_W(MAX_W), .CW(CW)) u_admit (
    .k_in  (k_in),
    .n_in  (n_in),
    .ok    (cfg_ok),
    .first (first_pat)
  );

  fwseq_next #(.MAX_W(MAX_W), .CW(CW)) u_next (
    .cur      (pat_q),
    .n_q      (n_q),
    .nxt      (succ_pat),
    .has_next (succ_ok)
  );

  // Action decode: load wins, a step only counts with a live pattern.
  always_comb begin
    if (load)                   act = ACT_LOAD;
    else if (step && vld_q)     act = succ_ok ? ACT_ADV : ACT_DONE;
    else                        act = ACT_HOLD;
  end

  always_comb begin
    pat_d  = pat_q;
    vld_d  = vld_q;
    n_d    = n_q;
    upd_en = 1'b1;
    case (act)
      ACT_LOAD: begin
        vld_d = cfg_ok;
        pat_d = cfg_ok ? first_pat : '0;
        n_d   = cfg_ok ? n_in : '0;
      end
      ACT_ADV:  pat_d = succ_pat;
      ACT_DONE: begin
        pat_d = '0;
        vld_d = 1'b0;
      end
      default:  upd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pat_q <= '0;
      vld_q <= 1'b0;
      n_q   <= '0;
    end else if (upd_en) begin
      pat_q <= pat_d;
      vld_q <= vld_d;
      n_q   <= n_d;
    end
  end

  assign pattern = pat_q;
  assign valid   = vld_q;
  assign last    = vld_q & ~succ_ok;
endmodule

// File: rtl/fwseq_chk.sv
module fwseq_chk #(
  parameter int MAX_W = 16,
  parameter int CW    = $clog2(MAX_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             step,
  input logic [CW-1:0]    k_in,
  input logic [CW-1:0]    n_in,
  input logic [MAX_W-1:0] pattern,
  input logic             valid,
  input logic             last,
  input logic [CW-1:0]    n_q
);
  logic bad_cfg;
  assign bad_cfg = (k_in == '0) || (n_in == '0) || (k_in > n_in) ||
                   (n_in > CW'(MAX_W));

  // R1 / R4: no pattern and no last flag without a live walk
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (pattern == '0) && !last);

  // R3: a step on a non-final pattern yields a different live pattern
  p_step_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && step && !last && !load |=> valid && (pattern != $past(pattern)));

  // R4: stepping past the final pattern ends the walk
  p_last_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && last && step && !load |=> !valid);

  // R5: rejected loads leave nothing valid
  p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load && bad_cfg |=> !valid);

  // R6: weight preserved across accepted steps
  p_weight_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && step && !last && !load |=>
      $countones(pattern) == $countones($past(pattern)));

  // R6: nothing set at or above the captured width
  p_above_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((pattern >> n_q) == '0));

  // R7: no command, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(pattern) && $stable(valid));
endmodule

bind fwseq_top fwseq_chk #(.MAX_W(MAX_W), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load    (load),
  .step    (step),
  .k_in    (k_in),
  .n_in    (n_in),
  .pattern (pattern),
  .valid   (valid),
  .last    (last),
  .n_q     (n_q)
);

// File: tb/test_fwseq_top.sv
module test_fwseq_top;
  localparam int MAX_W  = 16;
  localparam int CW     = $clog2(MAX_W + 1);
  localparam int T_CLK  = 10;
  localparam int WD_LIM = 150000;

  logic             clk;
  logic             rst_n;
  logic             load;
  logic             step;
  logic [CW-1:0]    k_in;
  logic [CW-1:0]    n_in;
  logic [MAX_W-1:0] pattern;
  logic             valid;
  logic             last;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit          m_valid;
  int unsigned m_pat;
  int unsigned m_n;

  fwseq_top #(.MAX_W(MAX_W)) i_fwseq_top (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .k_in(k_in), .n_in(n_in), .pattern(pattern), .valid(valid), .last(last)
  );

  initial clk = 1'b0;
  always #(T_CLK/2) clk = ~clk;

  // Next larger value with the same count of ones (integer view of R3).
  function automatic int unsigned ref_next(int unsigned p);
    int unsigned c, r;
    c = p & (~p + 1);
    r = p + c;
    return (((r ^ p) >> 2) / c) | r;
  endfunction

  function automatic bit ref_last();
    return m_valid && (ref_next(m_pat) >= (32'd1 << m_n));
  endfunction

  task automatic check_val(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check_val({req, " pattern"}, pattern, m_pat);
    check_val({req, " valid"}, valid, m_valid);
    check_val({req, " last"}, last, ref_last());
  endtask

  // One cycle: drive at negedge, update model at the edge, check next negedge.
  task automatic tick(bit ld, bit st, int k, int n, string req);
    load = ld; step = st; k_in = CW'(k); n_in = CW'(n);
    @(posedge clk);
    if (ld) begin
      if (k >= 1 && n >= 1 && k <= n && n <= MAX_W) begin
        m_valid = 1; m_pat = (32'd1 << k) - 1; m_n = n;
      end else begin
        m_valid = 0; m_pat = 0; m_n = 0;
      end
    end else if (st && m_valid) begin
      if (ref_next(m_pat) < (32'd1 << m_n)) m_pat = ref_next(m_pat);
      else begin m_valid = 0; m_pat = 0; end
    end
    @(negedge clk);
    check_all(req);
  endtask

  // Walk a full weight and compare against an explicit list (R8).
  task automatic walk_list(int n, int k, int unsigned exp_list[$]);
    tick(1, 0, k, n, "R2");
    foreach (exp_list[i]) begin
      check_val("R8 order", pattern, exp_list[i]);
      check_val("R4 last", last, (i == exp_list.size() - 1));
      if (i != exp_list.size() - 1) tick(0, 1, 0, 0, "R3");
    end
    tick(0, 1, 0, 0, "R4 drop");
  endtask

  task automatic walk_count(int n, int k, int exp_cnt);
    int seen = 1;
    tick(1, 0, k, n, "R2");
    while (valid && !last && seen < 20000) begin
      tick(0, 1, 0, 0, "R3");
      seen++;
    end
    check_val("R8 count", seen, exp_cnt);
    tick(0, 1, 0, 0, "R4 drop");
  endtask

  initial begin : watchdog
    repeat (WD_LIM) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    m_valid = 0; m_pat = 0; m_n = 0;
    load = 0; step = 0; k_in = '0; n_in = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1 after release");

    // R7: step with nothing valid is ignored
    tick(0, 1, 3, 5, "R7 idle step");

    // R8: n=3 directed order (value bit i = position i)
    walk_list(3, 1, '{32'h1, 32'h2, 32'h4});
    walk_list(3, 2, '{32'h3, 32'h5, 32'h6});
    walk_list(3, 3, '{32'h7});

    walk_count(5, 2, 10);
    walk_count(16, 1, 16);
    walk_count(16, 15, 16);
    walk_count(16, 16, 1);
    walk_count(7, 3, 35);

    // R5: rejected loads
    tick(1, 0, 0, 4, "R5 k zero");
    tick(1, 0, 5, 4, "R5 k above n");
    tick(1, 0, 1, 0, "R5 n zero");
    tick(1, 0, 3, 17, "R5 n above max");
    tick(0, 1, 0, 0, "R7 step after reject");

    // R7: load beats step; R5: bad load ends a live walk
    tick(1, 0, 2, 6, "R2");
    tick(0, 1, 0, 0, "R3");
    tick(1, 1, 3, 8, "R7 load priority");
    tick(0, 0, 9, 2, "R7 hold");
    tick(1, 0, 9, 2, "R5 reject live");

    // Random trials; k_in/n_in scrambled between loads (R7), R6 via model
    for (int t = 0; t < 40; t++) begin
      int n = 1 + $urandom % MAX_W;
      int k = 1 + $urandom % n;
      int len = 50 + $urandom % 250;
      tick(1, 0, k, n, "R2 random");
      for (int s = 0; s < len; s++) begin
        bit st = ($urandom % 4) != 0;
        tick(0, st, $urandom % 32, $urandom % 32, "R3 random");
        check_val("R6 upper bits", pattern >> n, 0);
        if (!m_valid) break;
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule